// File: doc/BRIEF.md
# Delta-Sigma ADC Read-on-Demand Sequencer

This block drives a serial delta-sigma converter over a four-wire SPI-style link, so that the host, not the converter, decides when each sample is fetched. After a start pulse it takes the converter out of continuous output and writes a block of configuration registers. It then leaves register access with a second stop-continuous byte, sends a resynchronisation command, and waits a settling interval so that the digital filter output is valid again. If the read command were sent without the second stop byte or before the filter has settled, the converter would never raise its data-ready indication.

Once settled, the block sits ready. Each host frame request sends one read-data command (0x12). The block then waits for the converter's active-low ready line and shifts in one 32-bit conversion word. The word is presented on a parallel output with a one-cycle valid strobe. If the ready line stays high past a configurable bound, a timeout flag is raised and the block returns to ready. The configuration bytes, the register start address, the sync opcode, the serial clock divider, the inter-frame gap and both wait bounds are parameters.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset the serial clock output is low, the sample valid strobe is low and the timeout flag is low, and no byte is sent until start_i is pulsed.
- R2: On start_i the block sends, each byte MSB first, in this order: 0x11, 0x40 OR the register start address (default address 1 gives 0x41), the configuration byte count minus one, the configuration bytes in parameter order (defaults 0x62 then 0x04), 0x11 again, and then the sync opcode (default 0x04). The serial clock idles low, the data line changes only while the clock is low, and the converter samples on the rising edge.
- R3: Every serial frame, whether a command byte or a data word, is preceded by at least GAP_CYC plus HALF_DIV system clocks with the serial clock low, counted from the end of the previous frame.
- R4: Frame requests are ignored before start and during initialisation. The first read command starts no earlier than SETTLE_CYC system clocks after the last bit of the sync byte.
- R5: In the ready state a frame request sends the single byte 0x12.
- R6: After the read command the block waits for the ready input to be low. It then clocks 32 bits, capturing the converter's output line MSB first on rising serial-clock edges, presents the word on sample_o and pulses sample_valid_o for exactly one cycle.
- R7: A frame request that arrives while a read command, its wait or its data transfer is in progress is dropped and sends no further byte.
- R8: If the ready input does not go low within DRDY_TIMEOUT system clocks after the read command ends, timeout_o goes high, no sample is produced and the block returns to ready. timeout_o stays high until the next accepted frame request clears it.
- R9: A frame request that falls in the same cycle as sample_valid_o is accepted and starts the next read command.
- R10: start_i after initialisation has finished has no effect and sends no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the initialisation sequence (pulse) |
| frame_req_i | input | 1 | Host request for the next sample (pulse) |
| sample_o | output | WORD_W | Last conversion word |
| sample_valid_o | output | 1 | One-cycle strobe marking a new word |
| timeout_o | output | 1 | Ready line did not fall in time |
| ser_clk_o | output | 1 | Serial clock to the converter |
| ser_mosi_o | output | 1 | Serial command and data line to the converter |
| ser_miso_i | input | 1 | Serial data line from the converter |
| rdy_ni | input | 1 | Converter data-ready, active low |

## Verification
Two events can meet in one cycle: the valid strobe that ends one read, and the host frame request that starts the next one. The bench waits for the strobe to be visible, then raises frame_req_i for that same cycle. It passes only if a second 0x12 byte reaches the converter model and a second word arrives. A request dropped in that cycle shows up as a missing byte and a missing sample in the scoreboard, and a request taken twice shows up as an unexpected byte.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [7:0] OP_STOP_CONT = 8'h11;
  localparam logic [7:0] OP_WREG      = 8'h40;
  localparam logic [7:0] OP_RDATA     = 8'h12;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_INIT, SEQ_SETTLE, SEQ_READY, SEQ_RDCMD, SEQ_WAIT, SEQ_RDDATA
  } seq_state_e;

  typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI, SH_GAP} sh_state_e;
endpackage

// File: rtl/adc_spi_shift.sv
module adc_spi_shift
  import adc_seq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       go_i,
  input  logic [$clog2(WORD_W+1)-1:0] nbits_i,
  input  logic [WORD_W-1:0]          tx_i,
  input  logic                       miso_i,
  output logic                       sclk_o,
  output logic                       mosi_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [WORD_W-1:0]          rx_o
);
  localparam int NB_W  = $clog2(WORD_W+1);
  localparam int CMAX  = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int HC_W  = $clog2(CMAX+1);

  sh_state_e         state_q;
  logic [HC_W-1:0]   cnt_q;
  logic [NB_W-1:0]   bits_q;
  logic [WORD_W-1:0] sh_q;

  assign mosi_o = sh_q[WORD_W-1];
  assign busy_o = (state_q != SH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      rx_o    <= '0;
      sclk_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        SH_IDLE: if (go_i) begin
          sh_q    <= tx_i;
          bits_q  <= nbits_i;
          cnt_q   <= '0;
          rx_o    <= '0;
          state_q <= SH_LO;
        end
        SH_LO: if (cnt_q == HC_W'(HALF_DIV-1)) begin
          cnt_q   <= '0;
          sclk_o  <= 1'b1;
          rx_o    <= {rx_o[WORD_W-2:0], miso_i};  // capture on rising edge
          state_q <= SH_HI;
        end else cnt_q <= cnt_q + 1'b1;
        SH_HI: if (cnt_q == HC_W'(HALF_DIV-1)) begin
          cnt_q   <= '0;
          sclk_o  <= 1'b0;
          sh_q    <= {sh_q[WORD_W-2:0], 1'b0};    // launch on falling edge
          bits_q  <= bits_q - 1'b1;
          state_q <= (bits_q == NB_W'(1)) ? SH_GAP : SH_LO;
        end else cnt_q <= cnt_q + 1'b1;
        SH_GAP: if (cnt_q == HC_W'(GAP_CYC-1)) begin
          cnt_q   <= '0;
          done_o  <= 1'b1;
          state_q <= SH_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assert_sclk_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  assert_mosi_stable_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  assert_frame_ends_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);
  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expired_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_expire_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !start_i) |=> !expired_o);
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int                    WORD_W       = 32,
  parameter int                    HALF_DIV     = 2,
  parameter int                    GAP_CYC      = 4,
  parameter logic [4:0]            CFG_ADDR     = 5'd1,
  parameter int                    CFG_NUM      = 2,
  parameter logic [CFG_NUM*8-1:0]  CFG_DATA     = 16'h6204,
  parameter logic [7:0]            SYNC_OP      = 8'h04,
  parameter int                    SETTLE_CYC   = 200,
  parameter int                    DRDY_TIMEOUT = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              frame_req_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              timeout_o,
  output logic              ser_clk_o,
  output logic              ser_mosi_o,
  input  logic              ser_miso_i,
  input  logic              rdy_ni
);
  localparam int INIT_LEN = CFG_NUM + 5;
  localparam int IDX_W    = $clog2(INIT_LEN);
  localparam int NB_W     = $clog2(WORD_W+1);
  localparam int TMR_MAX  = (SETTLE_CYC > DRDY_TIMEOUT) ? SETTLE_CYC : DRDY_TIMEOUT;
  localparam int CNT_W    = $clog2(TMR_MAX+1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pend_q;
  logic [1:0]        rdy_sync_q;
  logic [7:0]        init_byte, cur_byte;
  logic              sh_go, sh_busy, sh_done, last_init;
  logic [NB_W-1:0]   sh_nbits;
  logic [WORD_W-1:0] sh_tx, sh_rx;
  logic              tm_start, tm_exp;
  logic [CNT_W-1:0]  tm_load;

  always_comb begin
    init_byte = SYNC_OP;
    if (idx_q == IDX_W'(0))              init_byte = OP_STOP_CONT;
    else if (idx_q == IDX_W'(1))         init_byte = OP_WREG | {3'b000, CFG_ADDR};
    else if (idx_q == IDX_W'(2))         init_byte = 8'(CFG_NUM-1);
    else if (idx_q == IDX_W'(CFG_NUM+3)) init_byte = OP_STOP_CONT;  // leave register access
    for (int i = 0; i < CFG_NUM; i++)
      if (idx_q == IDX_W'(i+3)) init_byte = CFG_DATA[(CFG_NUM-1-i)*8 +: 8];
  end

  assign cur_byte  = (state_q == SEQ_RDCMD) ? OP_RDATA : init_byte;
  assign last_init = (idx_q == IDX_W'(INIT_LEN-1));
  assign sh_go     = !pend_q && (state_q == SEQ_INIT || state_q == SEQ_RDCMD ||
                                 state_q == SEQ_RDDATA);
  assign sh_nbits  = (state_q == SEQ_RDDATA) ? NB_W'(WORD_W) : NB_W'(8);
  assign sh_tx     = (state_q == SEQ_RDDATA) ? '0 : {cur_byte, {(WORD_W-8){1'b0}}};
  assign tm_start  = sh_done && ((state_q == SEQ_INIT && last_init) || state_q == SEQ_RDCMD);
  assign tm_load   = (state_q == SEQ_INIT) ? CNT_W'(SETTLE_CYC) : CNT_W'(DRDY_TIMEOUT);

  adc_spi_shift #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_shift (
    .clk_i, .rst_ni, .go_i(sh_go), .nbits_i(sh_nbits), .tx_i(sh_tx),
    .miso_i(ser_miso_i), .sclk_o(ser_clk_o), .mosi_o(ser_mosi_o),
    .busy_o(sh_busy), .done_o(sh_done), .rx_o(sh_rx)
  );

  adc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .start_i(tm_start), .load_i(tm_load), .expired_o(tm_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_sync_q <= 2'b11;
    else         rdy_sync_q <= {rdy_sync_q[0], rdy_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= SEQ_IDLE;
      idx_q          <= '0;
      pend_q         <= 1'b0;
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
      timeout_o      <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0;
      if (sh_go) pend_q <= 1'b1;
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_INIT;
          idx_q   <= '0;
        end
        SEQ_INIT: if (sh_done) begin
          pend_q <= 1'b0;
          if (last_init) state_q <= SEQ_SETTLE;
          else           idx_q   <= idx_q + 1'b1;
        end
        SEQ_SETTLE: if (tm_exp) state_q <= SEQ_READY;
        SEQ_READY: if (frame_req_i) begin
          state_q   <= SEQ_RDCMD;
          timeout_o <= 1'b0;
        end
        SEQ_RDCMD: if (sh_done) begin
          pend_q  <= 1'b0;
          state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: if (!rdy_sync_q[1]) state_q <= SEQ_RDDATA;
          else if (tm_exp) begin
            timeout_o <= 1'b1;
            state_q   <= SEQ_READY;
          end
        SEQ_RDDATA: if (sh_done) begin
          pend_q         <= 1'b0;
          sample_o       <= sh_rx;
          sample_valid_o <= 1'b1;
          state_q        <= SEQ_READY;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);
  assert_rdcmd_from_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RDCMD && $past(state_q) != SEQ_RDCMD) |->
      ($past(state_q) == SEQ_READY && $past(frame_req_i)));
  assert_no_sample_on_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !sample_valid_o);
  assert_clock_quiet_waiting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_SETTLE || state_q == SEQ_WAIT || state_q == SEQ_IDLE) |-> !ser_clk_o);
endmodule

// File: tb/tb_adc_cmd_seq.sv
`timescale 1ns/1ps
module tb_adc_cmd_seq;
  localparam int HALF = 2, GAP = 4, SETTLE = 200, TMO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, freq = 1'b0;
  logic [31:0] sample;
  logic valid, tmo, sclk, mosi;
  logic miso, rdy_n;

  always #10 clk = ~clk;

  adc_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_req_i(freq),
    .sample_o(sample), .sample_valid_o(valid), .timeout_o(tmo),
    .ser_clk_o(sclk), .ser_mosi_o(mosi), .ser_miso_i(miso), .rdy_ni(rdy_n)
  );

  // scoreboard storage: written by driver, consumed by monitor
  logic [7:0]  exp_bytes [64];
  logic [31:0] exp_words [64];
  int byte_wr = 0, word_wr = 0;
  logic drdy_en = 1'b1;
  int   drdy_dly = 20;
  int   t = 0, f = 0;
  logic done_flag = 1'b0;

  // converter model and monitor (single procedure)
  int byte_rd = 0, fire_idx = 0, mon_idx = 0, n_valid = 0, mt = 0, mf = 0;
  int cyc = 0, low_cnt = 0, cbits = 0, rd_bits = 0, arm_cnt = 0, t_last = 0;
  logic sclk_prev = 1'b0, reading = 1'b0, arm = 1'b0, seen_frame = 1'b0, first_rd = 1'b0;
  logic [7:0]  cmd = '0;
  logic [31:0] shw = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rdy_n = 1'b1; miso = 1'b0; reading = 1'b0; arm = 1'b0; cbits = 0; low_cnt = 0;
    end else begin
      if (arm) begin
        if (arm_cnt == 0) begin
          arm = 1'b0; rdy_n = 1'b0; reading = 1'b1; rd_bits = 0;
          shw = exp_words[fire_idx]; fire_idx++; miso = shw[31];
        end else arm_cnt--;
      end
      if (sclk && !sclk_prev) begin
        if ((reading && rd_bits == 0) || (!reading && cbits == 0)) begin
          if (seen_frame) begin
            mt++;
            if (low_cnt < GAP + HALF) begin
              mf++; $display("FAIL R3 gap before frame: got %0d expected >= %0d", low_cnt, GAP+HALF);
            end
          end
          seen_frame = 1'b1;
        end
        if (reading) begin
          rd_bits++;
          if (rd_bits == 32) begin reading = 1'b0; rdy_n = 1'b1; end
        end else begin
          cmd = {cmd[6:0], mosi}; cbits++;
          if (cbits == 8) begin
            cbits = 0; mt++;
            if (byte_rd >= byte_wr) begin
              mf++; $display("FAIL R7/R10 unexpected byte: got %02h expected none", cmd);
            end else begin
              if (cmd !== exp_bytes[byte_rd]) begin
                mf++; $display("FAIL R2/R5 byte %0d: got %02h expected %02h", byte_rd, cmd, exp_bytes[byte_rd]);
              end
              byte_rd++;
            end
            if (cmd == 8'h12) begin
              if (!first_rd) begin
                first_rd = 1'b1; mt++;
                if (cyc - t_last < SETTLE) begin
                  mf++; $display("FAIL R4 settle: got %0d expected >= %0d", cyc - t_last, SETTLE);
                end
              end
              if (drdy_en) begin arm = 1'b1; arm_cnt = drdy_dly; end
            end
            t_last = cyc;
          end
        end
        low_cnt = 0;
      end else if (!sclk) low_cnt++;
      if (!sclk && sclk_prev && reading) begin
        shw = {shw[30:0], 1'b0}; miso = shw[31];
      end
      sclk_prev = sclk;
      if (valid) begin
        mt++; n_valid++;
        if (mon_idx >= fire_idx) begin
          mf++; $display("FAIL R6 unexpected valid: got %08h expected none", sample);
        end else begin
          if (sample !== exp_words[mon_idx]) begin
            mf++; $display("FAIL R6 sample: got %08h expected %08h", sample, exp_words[mon_idx]);
          end
          mon_idx++;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    t++;
    if (!ok) begin f++; $display("FAIL %s: got %0d expected %0d", tag, act, exp); end
  endtask

  task automatic push_byte(input logic [7:0] b);
    exp_bytes[byte_wr] = b; byte_wr++;
  endtask

  task automatic push_word(input logic [31:0] w);
    exp_words[word_wr] = w; word_wr++;
  endtask

  task automatic pulse_req();
    freq = 1'b1; @(negedge clk); freq = 1'b0;
  endtask

  task automatic wait_valid(input int target);
    for (int i = 0; i < 8000 && n_valid < target; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] w, input int dly);
    int n0;
    n0 = n_valid;
    push_byte(8'h12); push_word(w); drdy_dly = dly;
    pulse_req();
    wait_valid(n0 + 1);
    chk(n_valid == n0 + 1, "R6 read completes", n_valid, n0 + 1);
  endtask

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R1 sclk low in reset", sclk, 0);
    chk(valid == 1'b0, "R1 valid low in reset", valid, 0);
    chk(tmo == 1'b0, "R1 timeout low in reset", tmo, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse_req();
    repeat (60) @(negedge clk);
    chk(byte_rd == 0 && sclk == 1'b0, "R1 no traffic before start", byte_rd, 0);

    // R2: init stream, then R4: requests during init/settle are dropped
    push_byte(8'h11); push_byte(8'h41); push_byte(8'h01); push_byte(8'h62);
    push_byte(8'h04); push_byte(8'h11); push_byte(8'h04);
    push_byte(8'h12); push_word(32'hA5C3_0F81); drdy_dly = 20;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000 && byte_rd < 8; i++) begin
      if (i % 16 == 0) freq = 1'b1;
      @(negedge clk); freq = 1'b0;
    end
    chk(byte_rd == 8, "R2 init bytes then first read", byte_rd, 8);
    wait_valid(1);
    chk(n_valid == 1, "R6 first sample", n_valid, 1);

    // R6: several data patterns and ready delays
    do_read(32'h0000_0001, 5);
    do_read(32'hFFFF_FFFF, 60);
    do_read(32'h8000_0000, 150);
    do_read(32'h0000_0000, 8);

    // R7: requests during wait and during data transfer are dropped
    n0 = n_valid;
    push_byte(8'h12); push_word(32'h1357_9BDF); drdy_dly = 40;
    pulse_req();
    for (int i = 0; i < 2000 && byte_rd < byte_wr; i++) @(negedge clk);
    repeat (5) @(negedge clk); pulse_req();
    for (int i = 0; i < 2000 && !reading; i++) @(negedge clk);
    repeat (10) @(negedge clk); pulse_req();
    wait_valid(n0 + 1);
    repeat (300) @(negedge clk);
    chk(byte_rd == byte_wr && n_valid == n0 + 1, "R7 no extra read", n_valid, n0 + 1);

    // R9: request in the same cycle as the valid strobe
    n0 = n_valid;
    push_byte(8'h12); push_word(32'hDEAD_BEEF);
    push_byte(8'h12); push_word(32'h0F0F_F0F0); drdy_dly = 12;
    pulse_req();
    for (int i = 0; i < 5000 && !valid; i++) @(negedge clk);
    freq = 1'b1; @(negedge clk); freq = 1'b0;
    wait_valid(n0 + 2);
    chk(n_valid == n0 + 2, "R9 same-cycle request accepted", n_valid, n0 + 2);
    chk(byte_rd == byte_wr, "R9 second read command sent", byte_rd, byte_wr);

    // R8: ready never falls
    n0 = n_valid;
    drdy_en = 1'b0; push_byte(8'h12);
    pulse_req();
    for (int i = 0; i < 2000 && byte_rd < byte_wr; i++) @(negedge clk);
    chk(tmo == 1'b0, "R8 no early timeout", tmo, 0);
    repeat (TMO - 40) @(negedge clk);
    chk(tmo == 1'b0, "R8 no timeout inside bound", tmo, 0);
    repeat (100) @(negedge clk);
    chk(tmo == 1'b1, "R8 timeout raised", tmo, 1);
    chk(n_valid == n0, "R8 no sample on timeout", n_valid, n0);
    drdy_en = 1'b1;
    push_byte(8'h12); push_word(32'h2468_ACE0); drdy_dly = 20;
    pulse_req();
    for (int i = 0; i < 2000 && byte_rd < byte_wr; i++) @(negedge clk);
    chk(tmo == 1'b0, "R8 timeout cleared by request", tmo, 0);
    wait_valid(n0 + 1);
    chk(n_valid == n0 + 1, "R8 recovers after timeout", n_valid, n0 + 1);

    // R10: start after init does nothing
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (400) @(negedge clk);
    chk(byte_rd == byte_wr, "R10 start ignored when running", byte_rd, byte_wr);
    do_read(32'h7654_3210, 30);

    repeat (50) @(negedge clk);
    chk(mon_idx == word_wr, "R6 all samples observed", mon_idx, word_wr);
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", t + mt, f + mf);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", t + mt + 1, f + mf + 1);
      $finish;
    end
  end
endmodule